// File: doc/BRIEF.md
# Interrupt Distributor

This block collects interrupt requests from devices and software in a small multi-core system and decides which CPU interfaces see them. Each source has an enable bit, a pending bit, a trigger mode and a CPU target field. A source that is enabled and pending raises the request line of every CPU interface named in its target field, provided forwarding is switched on globally. Priority selection and acknowledge handling belong to the CPU interfaces and are not part of this block.

Software uses a 32-bit register bus with a word address, a write strobe, a read strobe and the index of the CPU interface that makes the access. Read data is registered and appears one clock after the read strobe. Sources 0 to 31 are private: every CPU interface has its own copy of their enable and pending bits. Ids 0 to 15 are software interrupts. Ids 16 to 31 come from one input bundle per CPU. Ids 32 and up are shared and come from the `shr_irq` inputs.

Word addresses (byte offset divided by four): control 0x000, type 0x001, enable-set 0x040+k, enable-clear 0x060+k, pending-clear 0x0A0+k, target 0x200+id/2, trigger mode 0x300+k, software interrupt 0x3C0. Here k = id/32 and the bit within the word is id%32.

Top module: `irqd_dist`

## Requirements
- R1: Writing the enable-set word k sets the enable bit id%32 of source id = 32k + bit for every 1 in the data. A 0 bit leaves its enable unchanged. Reading either enable word returns the current enables.
- R2: Writing the enable-clear word k clears the enable of every source whose data bit is 1. A 0 bit leaves its enable unchanged.
- R3: The enable and pending bits of ids 0–31 are kept separately for each CPU interface. Reads and writes reach only the copy selected by `bus_cpu`.
- R4: In the trigger-mode words, bit 1 means rising edge and bit 0 means active-high level. Ids 0–15 always read 1 and ignore writes. All other ids are writable.
- R5: The target field of a shared id sits in word 0x200 + id/2 at bit (id%2)*16. Its low NUM_CPU bits select CPU interfaces. The field bits above NUM_CPU read as zero.
- R6: A target word of a private id (ids 0–31, words 0x200–0x20F) ignores writes. It reads the one-hot mask 1<<bus_cpu in both 16-bit halves.
- R7: The type word reads NUM_SRC/32 − 1 in bits [4:0] and zero elsewhere.
- R8: Writing the software interrupt word with target mask in bits [23:8] and id in bits [3:0] sets that id pending in the private copy of every CPU whose mask bit is 1.
- R9: Control bit 0 switches forwarding on. While it is 0, every `cpu_irq` line stays low.
- R10: An edge source becomes pending on a rising edge of its input. It stays pending until a 1 is written to its bit in the pending-clear word. A level source's pending bit follows its input one clock later. Reading a pending-clear word returns the pending bits.
- R11: `cpu_irq[c]` goes high two clocks after an input change when forwarding is on and some source is enabled, pending and aimed at c. Private sources are aimed only at their own CPU.
- R12: `bus_rdata` holds the addressed word from the clock edge that samples `bus_rd` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Word address (byte offset bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 2 | Index of the CPU interface making the access |
| bus_rdata | output | 32 | Registered read data |
| shr_irq | input | NUM_SRC-32 | Inputs of shared sources, bit s is id 32+s |
| prv_irq | input | 16*NUM_CPU | Private inputs, bit c*16+j is id 16+j of CPU c |
| cpu_irq | output | NUM_CPU | Registered request line per CPU interface |

## Verification
The assertions assume at most one register access per cycle and a `bus_cpu` value below NUM_CPU. They also assume reset is held from the first clock. The stimulus keeps within these limits. It drives a single access per task call, draws CPU indices modulo the CPU count, and draws target words only from the implemented range. Random enable-set and enable-clear traffic from random CPUs is compared against a model held in the bench. Directed sequences cover the edge, level, software and global-disable cases.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  // Word addresses of the register regions
  localparam logic [9:0] W_CTRL  = 10'h000;
  localparam logic [9:0] W_TYPE  = 10'h001;
  localparam logic [9:0] W_ENSET = 10'h040;
  localparam logic [9:0] W_ENCLR = 10'h060;
  localparam logic [9:0] W_PCLR  = 10'h0A0;
  localparam logic [9:0] W_TGT   = 10'h200;
  localparam logic [9:0] W_CFG   = 10'h300;
  localparam logic [9:0] W_SGI   = 10'h3C0;
  localparam int PRV_SRC = 32;
  localparam int SW_SRC  = 16;
endpackage

// File: rtl/irqd_pend_cell.sv
module irqd_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  input  logic edge_mode,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pend
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      sig_q <= sig_in;
      if (edge_mode) pend <= (pend & ~sw_clr) | (sig_in & ~sig_q) | sw_set;
      else           pend <= sig_in | sw_set;
    end
  end

  // R10: a rising edge in edge mode always leaves the source pending
  assert_edge_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && sig_in && !sig_q) |=> pend);
endmodule

// File: rtl/irqd_fwd.sv
module irqd_fwd #(
  parameter int NUM_CPU = 4,
  parameter int NUM_PRV = 32,
  parameter int NSH     = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             glob_en,
  input  logic [NUM_CPU-1:0][NUM_PRV-1:0]  prv_act,
  input  logic [NSH-1:0]                   sh_act,
  input  logic [NSH-1:0][NUM_CPU-1:0]      sh_tgt,
  output logic [NUM_CPU-1:0]               cpu_req
);
  logic [NUM_CPU-1:0] req_d;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      logic hit;
      hit = |prv_act[c];
      for (int s = 0; s < NSH; s++) hit = hit | (sh_act[s] & sh_tgt[s][c]);
      req_d[c] = glob_en & hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_req <= '0;
    else     cpu_req <= req_d;
  end

  // R9: no request leaves while forwarding was off
  assert_gated_off_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(glob_en) |-> (cpu_req == '0));
  // R11: an active private source of CPU 0 reaches CPU 0
  assert_prv_fwd_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(glob_en) && $past(|prv_act[0])) |-> cpu_req[0]);
endmodule

// File: rtl/irqd_dist.sv
module irqd_dist #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int NSH    = NUM_SRC - 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [11:2]               bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic [CPU_W-1:0]          bus_cpu,
  output logic [31:0]               bus_rdata,
  input  logic [NSH-1:0]            shr_irq,
  input  logic [16*NUM_CPU-1:0]     prv_irq,
  output logic [NUM_CPU-1:0]        cpu_irq
);
  import irqd_pkg::*;
  localparam int NW   = NUM_SRC / 32;
  localparam int NTGT = NUM_SRC / 2;

  logic                           glob_en;
  logic [NUM_CPU-1:0][31:0]       p_en, p_pend, p_set, p_clr;
  logic [NSH-1:0]                 s_en, s_pend, s_clr;
  logic [NSH-1:0][NUM_CPU-1:0]    s_tgt;
  logic [NUM_SRC-1:16]            cfg_q;
  logic [NUM_SRC-1:0]             edge_cfg, set_v, clr_v, pclr_v, all_en, all_pend;
  logic [31:0]                    rd_mux;
  logic [15:0]                    own_mask;

  assign edge_cfg = {cfg_q, 16'hFFFF};
  assign all_en   = {s_en, p_en[bus_cpu]};
  assign all_pend = {s_pend, p_pend[bus_cpu]};
  assign own_mask = 16'(1) << bus_cpu;

  // Write strobes spread over the flat source space
  always_comb begin
    set_v = '0; clr_v = '0; pclr_v = '0; p_set = '0;
    if (bus_wr) begin
      for (int k = 0; k < NW; k++) begin
        if (bus_addr == W_ENSET + 10'(k)) set_v[k*32 +: 32]  = bus_wdata;
        if (bus_addr == W_ENCLR + 10'(k)) clr_v[k*32 +: 32]  = bus_wdata;
        if (bus_addr == W_PCLR + 10'(k))  pclr_v[k*32 +: 32] = bus_wdata;
      end
      if (bus_addr == W_SGI)
        for (int c = 0; c < NUM_CPU; c++)
          if (bus_wdata[8+c]) p_set[c][bus_wdata[3:0]] = 1'b1;
    end
    p_clr = '0;
    p_clr[bus_cpu] = pclr_v[31:0];
    s_clr = pclr_v[NUM_SRC-1:32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      p_en    <= '0;
      s_en    <= '0;
      cfg_q   <= '0;
      s_tgt   <= '0;
    end else begin
      p_en[bus_cpu] <= (p_en[bus_cpu] | set_v[31:0]) & ~clr_v[31:0];
      s_en <= (s_en | set_v[NUM_SRC-1:32]) & ~clr_v[NUM_SRC-1:32];
      if (bus_wr) begin
        if (bus_addr == W_CTRL) glob_en <= bus_wdata[0];
        if (bus_addr == W_CFG) cfg_q[31:16] <= bus_wdata[31:16];
        for (int k = 1; k < NW; k++)
          if (bus_addr == W_CFG + 10'(k)) cfg_q[k*32 +: 32] <= bus_wdata;
        for (int t = PRV_SRC / 2; t < NTGT; t++)
          if (bus_addr == W_TGT + 10'(t)) begin
            s_tgt[2*t-32] <= bus_wdata[NUM_CPU-1:0];
            s_tgt[2*t-31] <= bus_wdata[16 +: NUM_CPU];
          end
      end
    end
  end

  // Pending state, one cell per source and private copy
  genvar c, i, s;
  generate
    for (c = 0; c < NUM_CPU; c++) begin : g_cpu
      for (i = 0; i < PRV_SRC; i++) begin : g_prv
        logic sig;
        if (i < SW_SRC) begin : g_sw
          assign sig = 1'b0;
        end else begin : g_hw
          assign sig = prv_irq[c*16 + i - SW_SRC];
        end
        irqd_pend_cell u_cell (
          .clk(clk), .rst(rst), .sig_in(sig), .edge_mode(edge_cfg[i]),
          .sw_set(p_set[c][i]), .sw_clr(p_clr[c][i]), .pend(p_pend[c][i]));
      end
    end
    for (s = 0; s < NSH; s++) begin : g_shr
      irqd_pend_cell u_cell (
        .clk(clk), .rst(rst), .sig_in(shr_irq[s]), .edge_mode(edge_cfg[32+s]),
        .sw_set(1'b0), .sw_clr(s_clr[s]), .pend(s_pend[s]));
    end
  endgenerate

  irqd_fwd #(.NUM_CPU(NUM_CPU), .NUM_PRV(PRV_SRC), .NSH(NSH)) u_fwd (
    .clk(clk), .rst(rst), .glob_en(glob_en),
    .prv_act(p_en & p_pend), .sh_act(s_en & s_pend),
    .sh_tgt(s_tgt), .cpu_req(cpu_irq));

  // Read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == W_CTRL) rd_mux[0] = glob_en;
    if (bus_addr == W_TYPE) rd_mux[4:0] = 5'(NW - 1);
    for (int k = 0; k < NW; k++) begin
      if (bus_addr == W_ENSET + 10'(k) || bus_addr == W_ENCLR + 10'(k))
        rd_mux = all_en[k*32 +: 32];
      if (bus_addr == W_PCLR + 10'(k)) rd_mux = all_pend[k*32 +: 32];
      if (bus_addr == W_CFG + 10'(k))  rd_mux = edge_cfg[k*32 +: 32];
    end
    for (int t = 0; t < NTGT; t++)
      if (bus_addr == W_TGT + 10'(t)) begin
        if (t < PRV_SRC / 2) rd_mux = {own_mask, own_mask};
        else begin
          rd_mux[NUM_CPU-1:0]    = s_tgt[2*t-32];
          rd_mux[16 +: NUM_CPU]  = s_tgt[2*t-31];
        end
      end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R1: zero bits of an enable-set write keep their enables
  assert_enset_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == W_ENSET + 10'd1) |=>
      (s_en[31:0] == ($past(s_en[31:0]) | $past(bus_wdata))));
  // R2: enable-clear removes exactly the written ones
  assert_enclr_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == W_ENCLR + 10'd1) |=>
      (s_en[31:0] == ($past(s_en[31:0]) & ~$past(bus_wdata))));
  // R3: another CPU's private enable write leaves CPU 0's copy alone
  assert_banked_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == W_ENSET && bus_cpu != '0) |=> $stable(p_en[0]));
  // R8: a software interrupt aimed at CPU 0 becomes pending there
  assert_sgi_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == W_SGI && bus_wdata[8]) |=> p_pend[0][$past(bus_wdata[3:0])]);
endmodule

// File: tb/irqd_dist_bench.sv
module irqd_dist_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;
  localparam int NCPU = 4;
  localparam logic [9:0] A_CTRL = 10'h000, A_TYPE = 10'h001, A_ENSET = 10'h040,
    A_ENCLR = 10'h060, A_PCLR = 10'h0A0, A_TGT = 10'h200, A_CFG = 10'h300, A_SGI = 10'h3C0;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0] bus_cpu = '0;
  logic [NSRC-33:0] shr_irq = '0;
  logic [16*NCPU-1:0] prv_irq = '0;
  logic [NCPU-1:0] cpu_irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] m_prv [NCPU];
  logic [31:0] m_shr;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqd_dist #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) u_irqd_dist (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .shr_irq(shr_irq), .prv_irq(prv_irq), .cpu_irq(cpu_irq));

  function automatic logic [31:0] exp_tgt(input logic [31:0] d);
    return d & 32'h000F_000F;
  endfunction
  function automatic logic [31:0] exp_own(input int c);
    return {2{16'(1 << c)}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input int c);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = 2'(c);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input int c, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_cpu = 2'(c);
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    for (int c = 0; c < NCPU; c++) m_prv[c] = '0;
    m_shr = '0;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(1);
    check("R9 reset cpu_irq", 32'(cpu_irq), 32'h0);
    rd(A_CTRL, 0, r); check("R12 reset ctrl", r, 32'h0);
    rd(A_TYPE, 0, r); check("R7 type", r, 32'h1);

    // R1 R2 R3: random enable traffic against the bench model
    for (int n = 0; n < 40; n++) begin
      int op, k, c, rc;
      logic [31:0] d;
      op = int'($urandom % 2); k = int'($urandom % 2);
      c = int'($urandom % NCPU); rc = int'($urandom % NCPU); d = $urandom;
      if (n == 0) d = 32'h0;
      wr((op != 0 ? A_ENCLR : A_ENSET) + 10'(k), d, c);
      if (k == 0) m_prv[c] = (op != 0) ? (m_prv[c] & ~d) : (m_prv[c] | d);
      else        m_shr    = (op != 0) ? (m_shr & ~d)    : (m_shr | d);
      rd(A_ENSET + 10'(k), rc, r);
      check(op != 0 ? "R2 enable clear" : "R1 R3 enable set",
            r, k == 0 ? m_prv[rc] : m_shr);
    end

    // R5 R6: target fields
    for (int n = 0; n < 16; n++) begin
      int t, c;
      logic [31:0] d;
      t = 16 + int'($urandom % 16); c = int'($urandom % NCPU); d = $urandom;
      wr(A_TGT + 10'(t), d, c);
      rd(A_TGT + 10'(t), int'($urandom % NCPU), r);
      check("R5 shared target", r, exp_tgt(d));
      t = int'($urandom % 16);
      wr(A_TGT + 10'(t), $urandom, c);
      rd(A_TGT + 10'(t), c, r);
      check("R6 private target", r, exp_own(c));
    end

    // R4: trigger-mode word 0
    wr(A_CFG, 32'h0, 1);
    rd(A_CFG, 2, r); check("R4 cfg fixed ones", r, 32'h0000_FFFF);
    wr(A_CFG, 32'hAAAA_0000, 0);
    rd(A_CFG, 0, r); check("R4 cfg writable upper", r, 32'hAAAA_FFFF);
    wr(A_CFG, 32'h0, 0);

    // clear all enables
    for (int c = 0; c < NCPU; c++) wr(A_ENCLR, 32'hFFFF_FFFF, c);
    wr(A_ENCLR + 10'd1, 32'hFFFF_FFFF, 0);

    // R9 R11 R10 level: id 40 aimed at CPU 2
    wr(A_ENSET + 10'd1, 32'h100, 0);
    wr(A_TGT + 10'd20, 32'h0000_0004, 0);
    shr_irq[8] = 1'b1;
    wait_clk(3);
    check("R9 forwarding off", 32'(cpu_irq), 32'h0);
    wr(A_CTRL, 32'h1, 0);
    wait_clk(3);
    check("R11 level forward", 32'(cpu_irq), 32'h4);
    shr_irq[8] = 1'b0;
    wait_clk(3);
    check("R10 level follows input", 32'(cpu_irq), 32'h0);

    // R10 edge: id 41 aimed at CPU 1
    wr(A_CFG + 10'd1, 32'h200, 0);
    wr(A_ENSET + 10'd1, 32'h200, 0);
    wr(A_TGT + 10'd20, 32'h0002_0004, 0);
    @(negedge clk); shr_irq[9] = 1'b1;
    @(negedge clk); shr_irq[9] = 1'b0;
    wait_clk(3);
    check("R10 edge latched", 32'(cpu_irq), 32'h2);
    rd(A_PCLR + 10'd1, 3, r); check("R10 edge pending read", r, 32'h200);
    wr(A_PCLR + 10'd1, 32'h200, 0);
    wait_clk(3);
    check("R10 edge cleared", 32'(cpu_irq), 32'h0);

    // R8 R3: software interrupt id 3 to CPUs 0 and 3
    wr(A_ENSET, 32'h8, 0);
    wr(A_ENSET, 32'h8, 3);
    wr(A_SGI, 32'h0000_0903, 1);
    wait_clk(3);
    check("R8 sgi forward", 32'(cpu_irq), 32'h9);
    rd(A_PCLR, 0, r); check("R8 sgi pending cpu0", r, 32'h8);
    rd(A_PCLR, 1, r); check("R3 sgi not on cpu1", r, 32'h0);
    wr(A_PCLR, 32'h8, 0);
    wait_clk(3);
    check("R3 clear only cpu0", 32'(cpu_irq), 32'h8);
    wr(A_CTRL, 32'h0, 0);
    wait_clk(3);
    check("R9 global off", 32'(cpu_irq), 32'h0);
    rd(A_CTRL, 0, r); check("R12 ctrl read", r, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule